// File: doc/BRIEF.md
# Dual-Register Configurable Logic Macrocell

This block is one output cell of a sum-of-products logic fabric. It receives the product terms of three four-term sum groups, five per-cell control terms (two clear terms, two clock terms, one output-enable term), a preset term shared with neighbouring cells and an external pin clock. It produces the output pin value, its enable, and two feedback signals returned to the array.

Two flip-flops live in the cell. Each can be set up on its own to load its data input (D) or to invert itself when that input is high (T). Each is clocked by its own product term, either alone or gated by the pin clock. A 9-bit configuration word chooses how the three sum groups are split between the two registers, whether the pin shows the first register or the combined sum directly, the pin polarity, and whether the second feedback carries the second register or bypasses it with that register's data input. All register activity is sampled on a single system clock. A register fires on the sample in which its effective clock term is first seen high.

Top module: `mc_macrocell`

## Requirements
- R1: While rst_ni is low both registers read 0, so fb1_o and fb2_o are 0 and, with cfg_i all zero, pin_o is 0.
- R2: cfg_i[1:0] picks how the sums are split. Sum group g is the OR of pterm_i[4g+3:4g]. With code 0, data input 1 is group 0 and data input 2 is groups 1 and 2. With code 1, data input 1 is groups 0 and 1 and data input 2 is group 2. With codes 2 and 3, data input 1 is all three groups and data input 2 is 0.
- R3: In D mode (cfg_i[5] for register 1, cfg_i[6] for register 2, value 0), a register loads its data input when its own clock fires. The other register is not disturbed.
- R4: In T mode (that bit at 1), a firing inverts the register when its data input is 1 and leaves it unchanged when the input is 0.
- R5: When cfg_i[7] is set (register 1) or cfg_i[8] is set (register 2), the effective clock is the clock term ANDed with pin_clk_i. Otherwise it is the clock term alone.
- R6: A register fires only on the sample where its effective clock goes from low to high. A clock held high causes no further loads.
- R7: When a register fires while preset_i is high, it is set to 1 in either mode.
- R8: A high clear term (clr_i[0] for register 1, clr_i[1] for register 2) sets that register to 0 on the next sample. This overrides both the preset and a firing clock. A clock edge that arrives during a clear is consumed. The other register is not affected.
- R9: cfg_i[2]=0 makes the pin show register 1. cfg_i[2]=1 makes the pin show data input 1 combinationally.
- R10: cfg_i[3]=1 inverts the pin value (active low). cfg_i[3]=0 passes it unchanged.
- R11: oe_o follows oe_term_i combinationally.
- R12: fb1_o is register 1. fb2_o is register 2 when cfg_i[4]=0, and data input 2 when cfg_i[4]=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-up clear) |
| pterm_i | input | 3*TERMS_PER_SUM | Product terms, three groups of TERMS_PER_SUM |
| clr_i | input | 2 | Clear terms for register 1 (bit 0) and register 2 (bit 1) |
| ck_i | input | 2 | Clock terms for register 1 (bit 0) and register 2 (bit 1) |
| oe_term_i | input | 1 | Output-enable product term |
| preset_i | input | 1 | Shared synchronous preset term |
| pin_clk_i | input | 1 | Pin clock used when clock gating is selected |
| cfg_i | input | 9 | Configuration word (fields given in R2 to R12) |
| pin_o | output | 1 | Output pin value |
| oe_o | output | 1 | Output pin enable |
| fb1_o | output | 1 | Register 1 feedback |
| fb2_o | output | 1 | Register 2 or bypassed data-input feedback |

## Verification
The split of the sums is probed by placing a single active term in one group and stepping through every merge code. The combinational pin and the bypassed feedback then show which register input that group reached. Register behaviour is driven by D loads, T toggles with the input high and low, and clocks held high. Gated clocking is exercised with each of its two inputs arriving last, which separates true edge detection from level sensitivity. Preset, clear and simultaneous clock are stacked on one sample to expose the priority order, and the register that was not addressed is checked to confirm it did not move.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned NUM_SUMS = 3;
  localparam int unsigned CFG_W    = 9;

  typedef enum logic [1:0] {
    MERGE_4  = 2'd0,
    MERGE_8  = 2'd1,
    MERGE_12 = 2'd2,
    MERGE_12B = 2'd3
  } merge_e;

  typedef struct packed {
    logic   pin_clk2;
    logic   pin_clk1;
    logic   t_mode2;
    logic   t_mode1;
    logic   fb_bypass;
    logic   active_low;
    logic   comb_out;
    merge_e merge;
  } cfg_t;
endpackage

// File: rtl/mc_sum_router.sv
module mc_sum_router
  import mc_pkg::*;
#(
  parameter int unsigned TERMS_PER_SUM = 4
) (
  input  logic [NUM_SUMS*TERMS_PER_SUM-1:0] pterm_i,
  input  merge_e                            merge_i,
  output logic                              dt1_o,
  output logic                              dt2_o
);
  logic [NUM_SUMS-1:0] sum_w;

  for (genvar g = 0; g < NUM_SUMS; g++) begin : g_sum
    assign sum_w[g] = |pterm_i[g*TERMS_PER_SUM +: TERMS_PER_SUM];
  end

  always_comb begin
    unique case (merge_i)
      MERGE_4: begin
        dt1_o = sum_w[0];
        dt2_o = sum_w[1] | sum_w[2];
      end
      MERGE_8: begin
        dt1_o = sum_w[0] | sum_w[1];
        dt2_o = sum_w[2];
      end
      default: begin
        dt1_o = |sum_w;
        dt2_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/mc_flop.sv
module mc_flop (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dt_i,
  input  logic ck_term_i,
  input  logic pin_clk_i,
  input  logic pin_gate_i,
  input  logic t_mode_i,
  input  logic clr_i,
  input  logic preset_i,
  output logic q_o
);
  logic ck_eff, ck_prev, fire;

  assign ck_eff = ck_term_i & (pin_clk_i | ~pin_gate_i);
  assign fire   = ck_eff & ~ck_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= 1'b0;
      ck_prev <= 1'b0;
    end else begin
      ck_prev <= ck_eff;
      if (clr_i)         q_o <= 1'b0;
      else if (fire) begin
        if (preset_i)    q_o <= 1'b1;
        else if (t_mode_i) q_o <= q_o ^ dt_i;
        else             q_o <= dt_i;
      end
    end
  end

  p_clear_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_o);

  p_preset_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && fire && preset_i) |=> q_o);

  p_hold_no_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !fire) |=> $stable(q_o));

  p_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && fire && !preset_i && t_mode_i && dt_i) |=> (q_o != $past(q_o)));
endmodule

// File: rtl/mc_out_sel.sv
module mc_out_sel (
  input  logic dt1_i,
  input  logic dt2_i,
  input  logic q1_i,
  input  logic q2_i,
  input  logic comb_out_i,
  input  logic active_low_i,
  input  logic fb_bypass_i,
  output logic pin_o,
  output logic fb1_o,
  output logic fb2_o
);
  logic raw_w;

  assign raw_w = comb_out_i ? dt1_i : q1_i;
  assign pin_o = raw_w ^ active_low_i;
  assign fb1_o = q1_i;
  assign fb2_o = fb_bypass_i ? dt2_i : q2_i;
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
  import mc_pkg::*;
#(
  parameter int unsigned TERMS_PER_SUM = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_SUMS*TERMS_PER_SUM-1:0] pterm_i,
  input  logic [1:0]                        clr_i,
  input  logic [1:0]                        ck_i,
  input  logic                              oe_term_i,
  input  logic                              preset_i,
  input  logic                              pin_clk_i,
  input  logic [CFG_W-1:0]                  cfg_i,
  output logic                              pin_o,
  output logic                              oe_o,
  output logic                              fb1_o,
  output logic                              fb2_o
);
  localparam int unsigned NUM_REGS = 2;

  cfg_t                cfg;
  logic                dt1, dt2;
  logic [NUM_REGS-1:0] dt_w, q_w, t_mode_w, gate_w;

  assign cfg = cfg_t'(cfg_i);

  mc_sum_router #(.TERMS_PER_SUM(TERMS_PER_SUM)) u_router (
    .pterm_i (pterm_i),
    .merge_i (cfg.merge),
    .dt1_o   (dt1),
    .dt2_o   (dt2)
  );

  assign dt_w     = {dt2, dt1};
  assign t_mode_w = {cfg.t_mode2, cfg.t_mode1};
  assign gate_w   = {cfg.pin_clk2, cfg.pin_clk1};

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    mc_flop u_flop (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .dt_i       (dt_w[r]),
      .ck_term_i  (ck_i[r]),
      .pin_clk_i  (pin_clk_i),
      .pin_gate_i (gate_w[r]),
      .t_mode_i   (t_mode_w[r]),
      .clr_i      (clr_i[r]),
      .preset_i   (preset_i),
      .q_o        (q_w[r])
    );
  end

  mc_out_sel u_out (
    .dt1_i        (dt1),
    .dt2_i        (dt2),
    .q1_i         (q_w[0]),
    .q2_i         (q_w[1]),
    .comb_out_i   (cfg.comb_out),
    .active_low_i (cfg.active_low),
    .fb_bypass_i  (cfg.fb_bypass),
    .pin_o        (pin_o),
    .fb1_o        (fb1_o),
    .fb2_o        (fb2_o)
  );

  assign oe_o = oe_term_i;

  p_comb_route_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[2] && !cfg_i[3] && cfg_i[1:0] == 2'd0)
      |-> (pin_o == |pterm_i[TERMS_PER_SUM-1:0]));
endmodule

// File: tb/tb_mc_macrocell.sv
`timescale 1ns/1ps
module tb_mc_macrocell;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pterm = '0;
  logic [1:0]  clr = '0, ck = '0;
  logic        oe_t = 1'b0, preset = 1'b0, pin_clk = 1'b0;
  logic [8:0]  cfg = '0;
  logic        pin, oe, fb1, fb2;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mc_macrocell dut (
    .clk_i(clk), .rst_ni(rst_n), .pterm_i(pterm), .clr_i(clr), .ck_i(ck),
    .oe_term_i(oe_t), .preset_i(preset), .pin_clk_i(pin_clk), .cfg_i(cfg),
    .pin_o(pin), .oe_o(oe), .fb1_o(fb1), .fb2_o(fb2)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, got, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; pterm = '0; clr = '0; ck = '0; oe_t = 0;
    preset = 0; pin_clk = 0; cfg = '0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic pulse(input int r);
    ck[r] = 1'b1; step();
    ck[r] = 1'b0; step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step();
    chk("R1 fb1", fb1, 0); chk("R1 fb2", fb2, 0); chk("R1 pin", pin, 0);
    rst_n = 1'b1; step();
  endtask

  task automatic t_merge();
    apply_reset();
    pterm = 12'h010; cfg = 9'h014; step();
    chk("R2 m0 g1 pin", pin, 0); chk("R2 m0 g1 fb2", fb2, 1);
    cfg = 9'h015; step();
    chk("R2 m1 g1 pin", pin, 1); chk("R2 m1 g1 fb2", fb2, 0);
    pterm = 12'h100; step();
    chk("R2 m1 g2 pin", pin, 0); chk("R2 m1 g2 fb2", fb2, 1);
    cfg = 9'h016; step();
    chk("R2 m2 g2 pin", pin, 1); chk("R2 m2 g2 fb2", fb2, 0);
    cfg = 9'h017; step();
    chk("R2 m3 g2 pin", pin, 1); chk("R2 m3 g2 fb2", fb2, 0);
    pterm = 12'h001; cfg = 9'h014; step();
    chk("R2 m0 g0 pin", pin, 1); chk("R2 m0 g0 fb2", fb2, 0);
  endtask

  task automatic t_d_mode();
    apply_reset();
    pterm = 12'h001; pulse(0);
    chk("R3 load q1", fb1, 1); chk("R3 q2 untouched", fb2, 0);
    pterm = 12'h020; pulse(1);
    chk("R3 load q2", fb2, 1); chk("R3 q1 untouched", fb1, 1);
    pterm = 12'h000; pulse(0);
    chk("R3 load q1 zero", fb1, 0); chk("R3 q2 kept", fb2, 1);
  endtask

  task automatic t_t_mode();
    apply_reset();
    cfg = 9'h060; pterm = 12'h001;
    pulse(0); chk("R4 toggle up", fb1, 1);
    pulse(0); chk("R4 toggle down", fb1, 0);
    pterm = 12'h000; pulse(0); chk("R4 hold t0", fb1, 0);
    pterm = 12'h200;
    pulse(1); chk("R4 q2 toggle up", fb2, 1);
    pulse(1); chk("R4 q2 toggle down", fb2, 0);
  endtask

  task automatic t_level();
    apply_reset();
    pterm = 12'h001; ck[0] = 1'b1; step();
    chk("R6 first edge", fb1, 1);
    pterm = 12'h000; step(); step();
    chk("R6 held high no load", fb1, 1);
    ck[0] = 1'b0; step();
    chk("R6 falling no load", fb1, 1);
  endtask

  task automatic t_pin_clk();
    apply_reset();
    cfg = 9'h080; pterm = 12'h001;
    pulse(0); chk("R5 gated off", fb1, 0);
    pin_clk = 1'b1; pulse(0); chk("R5 gated on", fb1, 1);
    pterm = 12'h000; pin_clk = 1'b0; ck[0] = 1'b1; step();
    chk("R5 term without pin", fb1, 1);
    pin_clk = 1'b1; step();
    chk("R5 pin arrives last", fb1, 0);
    ck[0] = 1'b0; pin_clk = 1'b0; step();
  endtask

  task automatic t_preset();
    apply_reset();
    preset = 1'b1; pulse(0);
    chk("R7 preset d", fb1, 1); chk("R7 q2 no clock", fb2, 0);
    cfg = 9'h020; pterm = 12'h001; pulse(0);
    chk("R7 preset beats toggle", fb1, 1);
    preset = 1'b0; pulse(0);
    chk("R7 toggle after preset", fb1, 0);
  endtask

  task automatic t_clear();
    apply_reset();
    pterm = 12'h011; pulse(0); pulse(1);
    chk("R8 setup q1", fb1, 1);
    clr[0] = 1'b1; preset = 1'b1; ck[0] = 1'b1; step();
    chk("R8 clear over preset", fb1, 0); chk("R8 q2 untouched", fb2, 1);
    clr[0] = 1'b0; step();
    chk("R8 edge consumed", fb1, 0);
    ck[0] = 1'b0; preset = 1'b0; clr[1] = 1'b1; step();
    chk("R8 clear q2 no clock", fb2, 0);
    clr[1] = 1'b0; step();
  endtask

  task automatic t_output();
    apply_reset();
    pterm = 12'h001; pulse(0); pterm = 12'h000;
    cfg = 9'h000; step(); chk("R9 registered", pin, 1);
    cfg = 9'h008; step(); chk("R10 registered low", pin, 0);
    cfg = 9'h004; step(); chk("R9 comb", pin, 0);
    cfg = 9'h00C; step(); chk("R10 comb low", pin, 1);
    pterm = 12'h001; cfg = 9'h004; step(); chk("R9 comb follows", pin, 1);
    oe_t = 1'b1; step(); chk("R11 oe high", oe, 1);
    oe_t = 1'b0; step(); chk("R11 oe low", oe, 0);
  endtask

  task automatic t_feedback();
    apply_reset();
    pterm = 12'h010; step();
    chk("R12 fb2 register", fb2, 0);
    cfg = 9'h010; step(); chk("R12 fb2 bypass", fb2, 1);
    pterm = 12'h000; step(); chk("R12 fb2 bypass low", fb2, 0);
    chk("R12 fb1 register", fb1, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_merge();
    t_d_mode();
    t_t_mode();
    t_level();
    t_pin_clk();
    t_preset();
    t_clear();
    t_output();
    t_feedback();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule